// File: doc/BRIEF.md
# I/Q Amplitude Modulator Stage

This block sits between a sine/cosine lookup stage and a 10-bit current-output DAC in a direct digital synthesis datapath. Each clock it accepts one signed sine sample and one signed cosine sample. The sine sample is scaled by a quadrature gain and the cosine sample by an in-phase gain. The two gains are signed fractions held together in one 20-bit gain register. The block adds the two scaled values in fixed-width arithmetic and presents the result to the DAC as an offset-binary code.

A single enable input chooses between modulated output and a pass-through. In pass-through the raw sine sample drives the DAC. The pass-through has the same pipeline latency as the modulated path, so changing the enable leaves no gap and no misaligned sample in the output stream. The sum is not saturated: when the two products add past the signed range, the result wraps. The gain setting is what keeps the sum in range.

Top module: `iq_amp_mod`

## Requirements
- R1: While `rst_n` is low at a rising edge, the gain register clears to zero and `dac_code` becomes 10'h200 (signed zero in offset binary). With zero gain and the enable high, every output is 10'h200.
- R2: When `gain_wr_en` is high at a rising edge, the gain register loads `gain_wr_data`. Bits [19:10] form the quadrature gain, which scales the sine sample. Bits [9:0] form the in-phase gain, which scales the cosine sample. A new gain applies to samples presented in the cycle after the write and later.
- R3: Each scaled value is the full signed 10x10 product of its sample and its gain, shifted right arithmetically by 9 bits, with the low 10 bits kept. Examples: gain 10'h1FF on a sample of 256 gives 255; gain 10'h200 on a sample of 100 gives -100.
- R4: The two scaled values are added modulo 2^10. An overflow wraps and is never clipped. For example, 510 + 510 gives -4.
- R5: When `am_enable` is low, the output carries the raw sine sample, and the cosine sample and both gains have no effect.
- R6: `dac_code` is the 10-bit signed result with its MSB inverted (offset binary).
- R7: A sample pair and its enable, presented before rising edge k, appear on `dac_code` after rising edge k+1. This holds on both the modulated and the pass-through paths.
- R8: When `gain_wr_en` is low, the gain register holds its value whatever `gain_wr_data` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sin_smp | input | 10 | Signed sine sample from the lookup stage |
| cos_smp | input | 10 | Signed cosine sample from the lookup stage |
| gain_wr_en | input | 1 | Gain register write strobe |
| gain_wr_data | input | 20 | Packed gains: [19:10] quadrature, [9:0] in-phase |
| am_enable | input | 1 | 1 = modulated sum, 0 = sine pass-through |
| dac_code | output | 10 | Offset-binary code toward the DAC |

## Verification
The bench drives the largest positive gain and the most negative gain (10'h200). These show whether the product keeps its sign and is shifted arithmetically rather than logically. A logical shift turns -100 into a large positive code. It forces a sum of 510 + 510 that must wrap to -4. A saturating adder would give 511 here, and a wider sum would show the wrong MSB. It also toggles the enable mid-stream and writes gain data with the strobe low. A pass-through with one register too few would present each sample one cycle early. A write path that ignores the strobe would change the later outputs.

// File: rtl/iq_mod_pkg.sv
// Package: shared constants and helpers for the I/Q amplitude modulator.
// Assumes samples and gains share one width; the default is 10 bits.
package iq_mod_pkg;
    localparam int unsigned SMP_W_DEF = 10;
    localparam int unsigned N_CHAN    = 2;
    localparam int unsigned CH_Q      = 0;   // quadrature: sine channel
    localparam int unsigned CH_I      = 1;   // in-phase: cosine channel
endpackage

// File: rtl/iq_gain_reg.sv
// Module: holds the packed pair of channel gains.
// The upper half is the quadrature gain and the lower half the in-phase gain.
// Reset is synchronous and active-low and clears both gains.
module iq_gain_reg #(
    parameter int unsigned W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [2*W-1:0] wr_data,
    output logic [W-1:0]   gain_q,
    output logic [W-1:0]   gain_i
);
    logic [2*W-1:0] gain_r;

    // Purpose: load the packed gains on a strobe, otherwise hold them.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gain_r <= '0;
        else if (wr_en)
            gain_r <= wr_data;
    end

    assign gain_q = gain_r[2*W-1:W];
    assign gain_i = gain_r[W-1:0];
endmodule

// File: rtl/iq_scale.sv
// Module: one channel multiplier. It forms the signed product of a sample
// and a fractional gain and shifts it right arithmetically by W-1 bits.
// Only the low W bits are kept, so a -1 x -1 product wraps.
// The output is registered: this is pipeline stage one.
module iq_scale #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp,
    input  logic [W-1:0] gain,
    output logic [W-1:0] prod
);
    localparam int unsigned PW = 2 * W;
    localparam int unsigned SH = W - 1;

    logic signed [PW-1:0] smp_x;
    logic signed [PW-1:0] gain_x;
    logic signed [PW-1:0] full;
    logic        [W-1:0]  prod_n;

    // Purpose: sign-extend the operands, multiply, then scale the fraction.
    always_comb begin
        smp_x  = signed'({{W{smp[W-1]}}, smp});
        gain_x = signed'({{W{gain[W-1]}}, gain});
        full   = smp_x * gain_x;
        prod_n = W'(full >>> SH);
    end

    // Purpose: register the scaled product.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prod <= '0;
        else
            prod <= prod_n;
    end
endmodule

// File: rtl/iq_combine.sv
// Module: adds the two scaled channels modulo 2^W, or passes the sine
// sample through. The result is converted to offset binary.
// The sine sample and the enable are delayed one stage so that the
// pass-through has the same latency as the multiply path.
module iq_combine #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] prod_a,
    input  logic [W-1:0] prod_b,
    input  logic [W-1:0] byp_smp,
    input  logic         en,
    output logic [W-1:0] code
);
    localparam logic [W-1:0] MSB_FLIP = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] byp_q;
    logic         en_q;
    logic [W-1:0] res_n;

    // Purpose: stage-one alignment of the pass-through sample and the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_q <= '0;
            en_q  <= 1'b0;
        end else begin
            byp_q <= byp_smp;
            en_q  <= en;
        end
    end

    // Purpose: select the wrapped sum or the raw sine.
    always_comb begin
        res_n = en_q ? (prod_a + prod_b) : byp_q;
    end

    // Purpose: stage-two output register in offset binary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code <= MSB_FLIP;
        else
            code <= res_n ^ MSB_FLIP;
    end
endmodule

// File: rtl/iq_amp_mod.sv
// Module: top of the I/Q amplitude modulator stage.
// The gain register feeds two channel multipliers built by a generate loop.
// Their products are summed or bypassed, then sent to the DAC code output.
// Latency is two clocks on both paths.
module iq_amp_mod #(
    parameter int unsigned W = iq_mod_pkg::SMP_W_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   sin_smp,
    input  logic [W-1:0]   cos_smp,
    input  logic           gain_wr_en,
    input  logic [2*W-1:0] gain_wr_data,
    input  logic           am_enable,
    output logic [W-1:0]   dac_code
);
    import iq_mod_pkg::*;

    logic [W-1:0] gain_w [N_CHAN];
    logic [W-1:0] smp_w  [N_CHAN];
    logic [W-1:0] prod_w [N_CHAN];

    iq_gain_reg #(.W(W)) u_gain (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (gain_wr_en),
        .wr_data (gain_wr_data),
        .gain_q  (gain_w[CH_Q]),
        .gain_i  (gain_w[CH_I])
    );

    assign smp_w[CH_Q] = sin_smp;
    assign smp_w[CH_I] = cos_smp;

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        iq_scale #(.W(W)) u_scale (
            .clk   (clk),
            .rst_n (rst_n),
            .smp   (smp_w[c]),
            .gain  (gain_w[c]),
            .prod  (prod_w[c])
        );
    end

    iq_combine #(.W(W)) u_comb (
        .clk     (clk),
        .rst_n   (rst_n),
        .prod_a  (prod_w[CH_Q]),
        .prod_b  (prod_w[CH_I]),
        .byp_smp (sin_smp),
        .en      (am_enable),
        .code    (dac_code)
    );
endmodule

// File: rtl/iq_amp_mod_chk.sv
// Checker: temporal properties of the I/Q modulator. It is bound into the
// top and sees the gain register and the stage-one products.
module iq_amp_mod_chk #(
    parameter int unsigned W = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic [W-1:0]   sin_smp,
    input logic           gain_wr_en,
    input logic [2*W-1:0] gain_wr_data,
    input logic           am_enable,
    input logic [W-1:0]   dac_code,
    input logic [W-1:0]   g_q,
    input logic [W-1:0]   g_i,
    input logic [W-1:0]   p_q,
    input logic [W-1:0]   p_i
);
    logic [1:0] up;
    logic       rst_d;

    function automatic logic [W-1:0] offs(input logic [W-1:0] v);
        return {~v[W-1], v[W-2:0]};
    endfunction

    // Purpose: count the cycles since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)       up <= '0;
        else if (up != 3) up <= up + 2'd1;
        rst_d <= rst_n;
    end

    // R1: the output sits at midscale right after a reset edge.
    always @(negedge clk) begin
        if (rst_d === 1'b0)
            a_r1_reset_mid: assert (dac_code == offs('0));
    end

    a_r2_gain_load: assert property (@(posedge clk) disable iff (!rst_n)
        gain_wr_en |=> {g_q, g_i} == $past(gain_wr_data));

    a_r8_gain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !gain_wr_en |=> $stable({g_q, g_i}));

    a_r4_wrap_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (up == 2'd3 && $past(am_enable, 2)) |->
            dac_code == offs($past(p_q) + $past(p_i)));

    a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (up == 2'd3 && !$past(am_enable, 2)) |->
            dac_code == offs($past(sin_smp, 2)));

    a_r3_zero_gain: assert property (@(posedge clk) disable iff (!rst_n)
        (up != 2'd0 && g_q == '0) |=> p_q == '0);
endmodule

bind iq_amp_mod iq_amp_mod_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sin_smp      (sin_smp),
    .gain_wr_en   (gain_wr_en),
    .gain_wr_data (gain_wr_data),
    .am_enable    (am_enable),
    .dac_code     (dac_code),
    .g_q          (gain_w[iq_mod_pkg::CH_Q]),
    .g_i          (gain_w[iq_mod_pkg::CH_I]),
    .p_q          (prod_w[iq_mod_pkg::CH_Q]),
    .p_i          (prod_w[iq_mod_pkg::CH_I])
);

// File: tb/sim_iq_amp_mod.sv
module sim_iq_amp_mod;
    localparam int W = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [W-1:0]   sin_smp = '0;
    logic [W-1:0]   cos_smp = '0;
    logic           gain_wr_en = 1'b0;
    logic [2*W-1:0] gain_wr_data = '0;
    logic           am_enable = 1'b0;
    logic [W-1:0]   dac_code;

    int checks = 0;
    int errors = 0;

    logic [2*W-1:0] g_model = '0;
    logic [W-1:0]   e1 = '0, e2 = '0;
    bit             v1 = 0, v2 = 0;
    string          t1 = "", t2 = "";

    always #10 clk = ~clk;

    iq_amp_mod #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .sin_smp(sin_smp), .cos_smp(cos_smp),
        .gain_wr_en(gain_wr_en), .gain_wr_data(gain_wr_data),
        .am_enable(am_enable), .dac_code(dac_code)
    );

    function automatic logic [W-1:0] scale(input logic [W-1:0] s, input logic [W-1:0] g);
        int p;
        p = $signed(s) * $signed(g);
        p = p >>> (W - 1);
        return p[W-1:0];
    endfunction

    function automatic logic [W-1:0] model(input logic [W-1:0] s, input logic [W-1:0] c,
                                           input logic en, input logic [2*W-1:0] g);
        logic [W-1:0] r;
        r = en ? scale(s, g[2*W-1:W]) + scale(c, g[W-1:0]) : s;
        return {~r[W-1], r[W-2:0]};
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: dac_code=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: check the sample driven two calls earlier, then drive new inputs.
    task automatic cyc(input logic [W-1:0] s, input logic [W-1:0] c, input logic en,
                       input logic we, input logic [2*W-1:0] wd, input string tag);
        @(negedge clk);
        if (v2) check(t2, dac_code, e2);
        e2 = e1; v2 = v1; t2 = t1;
        e1 = model(s, c, en, g_model); v1 = (tag != ""); t1 = tag;
        if (we) g_model = wd;
        sin_smp = s; cos_smp = c; am_enable = en;
        gain_wr_en = we; gain_wr_data = wd;
    endtask

    task automatic flush();
        repeat (2) cyc('0, '0, 1'b0, 1'b0, '0, "");
    endtask

    initial begin
        #(20 * 5000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check("R1 reset midscale", dac_code, 10'h200);
        rst_n = 1'b1;
        // R1: zero gain after reset gives midscale with the enable high
        cyc(10'h1FF, 10'h1FF, 1'b1, 1'b0, '0, "R1 zero gain");
        cyc(10'h200, 10'h155, 1'b1, 1'b0, '0, "R1 zero gain neg");
        // R2 R3: maximum positive quadrature gain, zero in-phase gain
        cyc('0, '0, 1'b1, 1'b1, {10'h1FF, 10'h000}, "");
        cyc(10'd256, 10'd300, 1'b1, 1'b0, '0, "R3 max gain 256->255");
        cyc(10'h1FF, 10'h000, 1'b1, 1'b0, '0, "R3 max gain full scale");
        // R3: most negative gain on both channels
        cyc('0, '0, 1'b1, 1'b1, {10'h200, 10'h200}, "");
        cyc(10'd100, 10'd0, 1'b1, 1'b0, '0, "R3 negative gain");
        cyc(10'h200, 10'h000, 1'b1, 1'b0, '0, "R3 product wrap -1x-1");
        // R4: forced sum wrap: 510 + 510 wraps to -4 (code 10'h1FC)
        cyc('0, '0, 1'b1, 1'b1, {10'h1FF, 10'h1FF}, "");
        cyc(10'h1FF, 10'h1FF, 1'b1, 1'b0, '0, "R4 sum wrap");
        // R8: write data with the strobe low leaves the gains unchanged
        cyc(10'h1FF, 10'h1FF, 1'b1, 1'b0, 20'h00000, "R8 hold gains");
        cyc(10'h1FF, 10'h1FF, 1'b1, 1'b0, 20'hFFFFF, "R8 hold gains 2");
        // R5 R6 R7: pass-through toggled mid-stream with a fixed two-cycle latency
        cyc(10'h3FD, 10'h123, 1'b0, 1'b0, '0, "R5 bypass -3");
        cyc(10'h1FF, 10'h1FF, 1'b1, 1'b0, '0, "R7 enable toggle");
        cyc(10'h07B, 10'h200, 1'b0, 1'b0, '0, "R6 bypass offset binary");
        cyc(10'h200, 10'h000, 1'b0, 1'b0, '0, "R5 bypass min");
        flush();
        // Random mix; every check exercises R3 R4 R5 R6 R7
        for (int i = 0; i < 400; i++) begin
            logic we;
            we = ($urandom % 8) == 0;
            cyc(W'($urandom), W'($urandom), 1'($urandom), we, 20'($urandom), "R4 random");
        end
        flush();
        // R1: a reset in mid-stream restores midscale and zero gain
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again", dac_code, 10'h200);
        rst_n = 1'b1; g_model = '0; v1 = 0; v2 = 0;
        cyc(10'h155, 10'h0AA, 1'b1, 1'b0, '0, "R1 gain cleared");
        flush();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule